// File: doc/BRIEF.md
# UART Interrupt Enable and Status Register Bank

This block gathers thirteen single-cycle event pulses from a UART and turns them into one level-sensitive interrupt line. Each pulse sets a sticky status bit that software clears by writing one to it. A separate mask decides which pending bits may raise the interrupt. Software changes the mask only through two write-only ports: one sets the chosen mask bits and the other clears them. A third, read-only port returns the current mask.

The four registers sit on a simple register bus that completes in one cycle. A write takes effect at the clock edge where `wr_en_i` is high. Reads have no side effects: `rdata_o` is a combinational view of the register selected by `addr_i`. The interrupt output is registered, so it follows the masked status one cycle later.

Top module: `uart_irq_regs`

## Requirements
- R1: After reset, all mask bits, all status bits and `irq_o` are zero.
- R2: A write to offset 0x08 sets every mask bit k for which `wdata_i[k]` is one and leaves the other mask bits unchanged.
- R3: A write to offset 0x0C clears every mask bit k for which `wdata_i[k]` is one and leaves the other mask bits unchanged.
- R4: The mask register at offset 0x10 is read-only. A write to 0x10, or to any offset other than 0x08, 0x0C and 0x14, changes neither the mask nor the status.
- R5: A one on `event_i[k]` at a clock edge sets status bit k. The bit then stays set, with the event input low, until software clears it.
- R6: A write to offset 0x14 clears every status bit k for which `wdata_i[k]` is one. Status bits written with zero are unchanged.
- R7: If an event and a clearing write hit the same status bit at the same edge, the bit ends up set.
- R8: Status bits latch events whether or not the matching mask bit is set.
- R9: `irq_o` at each edge takes the OR of (status AND mask) as it stood before that edge. It therefore rises one cycle after a masked-in status bit is set, and falls one cycle after the last such bit is cleared or masked off.
- R10: A read of 0x10 returns the mask and a read of 0x14 returns the status, both in bits 12:0 with bits 31:13 zero. Reads of 0x08, 0x0C and all other offsets return zero.
- R11: Status and mask bit positions are:
  - bit 0: receive threshold reached
  - bit 1: receive queue empty
  - bit 2: receive queue full
  - bit 3: transmit queue empty
  - bit 4: transmit queue full
  - bit 5: receive overflow
  - bit 6: framing error
  - bit 7: parity error
  - bit 8: receive idle timeout
  - bit 9: modem line change
  - bit 10: transmit threshold reached
  - bit 11: transmit queue nearly full
  - bit 12: transmit overflow

  `event_i[k]` feeds status bit k.
- R12: Writing 0x1FFF to 0x0C masks every source. Writing 0x1FFF to 0x14 clears every pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register byte offset |
| wr_en_i | input | 1 | Write strobe for the current cycle |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| event_i | input | 13 | One-cycle event pulses, one per source |
| irq_o | output | 1 | Registered level interrupt |

## Verification
The bound checker checks the following on every cycle:
- each status bit stays set unless a clear write targets it;
- an event always leaves its bit set, including when a clear targets the same bit;
- a clear with no competing event empties the bit;
- the mask moves only on set or clear writes;
- `irq_o` tracks the masked status of the previous cycle;
- read data matches the addressed register.

The bench's scenarios show the rest. These cover:
- set and clear writes that leave untouched mask bits intact;
- an event on a masked-off source that stays pending but silent, then raises the interrupt once enabled;
- writes to the read-only and unused offsets that leave the state unchanged;
- all-ones clears.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int unsigned IRQ_SRC_N = 13;
  localparam int unsigned BUS_AW    = 8;
  localparam int unsigned BUS_DW    = 32;

  localparam logic [BUS_AW-1:0] OFS_SET  = 8'h08;
  localparam logic [BUS_AW-1:0] OFS_CLR  = 8'h0C;
  localparam logic [BUS_AW-1:0] OFS_MASK = 8'h10;
  localparam logic [BUS_AW-1:0] OFS_STAT = 8'h14;

  // source bit positions (R11)
  localparam int unsigned SRC_RX_THRESH  = 0;
  localparam int unsigned SRC_RX_EMPTY   = 1;
  localparam int unsigned SRC_RX_FULL    = 2;
  localparam int unsigned SRC_TX_EMPTY   = 3;
  localparam int unsigned SRC_TX_FULL    = 4;
  localparam int unsigned SRC_RX_OVF     = 5;
  localparam int unsigned SRC_FRAME_ERR  = 6;
  localparam int unsigned SRC_PARITY_ERR = 7;
  localparam int unsigned SRC_RX_IDLE    = 8;
  localparam int unsigned SRC_MODEM_CHG  = 9;
  localparam int unsigned SRC_TX_THRESH  = 10;
  localparam int unsigned SRC_TX_NFULL   = 11;
  localparam int unsigned SRC_TX_OVF     = 12;
endpackage

// File: rtl/uart_irq_decode.sv
module uart_irq_decode #(
  parameter int unsigned       ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] OFS_SET  = 8'h08,
  parameter logic [ADDR_W-1:0] OFS_CLR  = 8'h0C,
  parameter logic [ADDR_W-1:0] OFS_MASK = 8'h10,
  parameter logic [ADDR_W-1:0] OFS_STAT = 8'h14
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  output logic              set_wr_o,
  output logic              clr_wr_o,
  output logic              stat_wr_o,
  output logic              mask_rd_o,
  output logic              stat_rd_o
);
  always_comb begin
    set_wr_o  = wr_en_i && (addr_i == OFS_SET);
    clr_wr_o  = wr_en_i && (addr_i == OFS_CLR);
    stat_wr_o = wr_en_i && (addr_i == OFS_STAT);
    mask_rd_o = (addr_i == OFS_MASK);
    stat_rd_o = (addr_i == OFS_STAT);
  end
endmodule

// File: rtl/uart_irq_mask.sv
module uart_irq_mask #(
  parameter int unsigned N = 13
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [N-1:0] bits_i,
  output logic [N-1:0] mask_o
);
  logic [N-1:0] set_v, clr_v;

  assign set_v = set_i ? bits_i : '0;
  assign clr_v = clr_i ? bits_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_o <= '0;
    else         mask_o <= (mask_o | set_v) & ~clr_v;
  end
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status #(
  parameter int unsigned N = 13
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] event_i,
  input  logic         clr_i,
  input  logic [N-1:0] bits_i,
  output logic [N-1:0] stat_o
);
  for (genvar k = 0; k < N; k++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  stat_o[k] <= 1'b0;
      else if (event_i[k])          stat_o[k] <= 1'b1; // event wins over clear
      else if (clr_i && bits_i[k])  stat_o[k] <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_irq_regs.sv
module uart_irq_regs
  import uart_irq_pkg::*;
#(
  parameter int unsigned       N        = IRQ_SRC_N,
  parameter int unsigned       ADDR_W   = BUS_AW,
  parameter int unsigned       DATA_W   = BUS_DW,
  parameter logic [ADDR_W-1:0] A_SET    = OFS_SET,
  parameter logic [ADDR_W-1:0] A_CLR    = OFS_CLR,
  parameter logic [ADDR_W-1:0] A_MASK   = OFS_MASK,
  parameter logic [ADDR_W-1:0] A_STAT   = OFS_STAT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N-1:0]      event_i,
  output logic              irq_o
);
  logic         set_wr, clr_wr, stat_wr, mask_rd, stat_rd;
  logic [N-1:0] wbits;
  logic [N-1:0] mask_q, status_q;
  logic         unused_wdata;

  assign wbits        = wdata_i[N-1:0];
  assign unused_wdata = ^wdata_i[DATA_W-1:N];

  uart_irq_decode #(
    .ADDR_W(ADDR_W), .OFS_SET(A_SET), .OFS_CLR(A_CLR),
    .OFS_MASK(A_MASK), .OFS_STAT(A_STAT)
  ) u_dec (
    .addr_i(addr_i), .wr_en_i(wr_en_i),
    .set_wr_o(set_wr), .clr_wr_o(clr_wr), .stat_wr_o(stat_wr),
    .mask_rd_o(mask_rd), .stat_rd_o(stat_rd)
  );

  uart_irq_mask #(.N(N)) u_mask (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .set_i(set_wr), .clr_i(clr_wr), .bits_i(wbits),
    .mask_o(mask_q)
  );

  uart_irq_status #(.N(N)) u_stat (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .event_i(event_i), .clr_i(stat_wr), .bits_i(wbits),
    .stat_o(status_q)
  );

  always_comb begin
    rdata_o = '0;
    if (mask_rd)      rdata_o[N-1:0] = mask_q;
    else if (stat_rd) rdata_o[N-1:0] = status_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |(status_q & mask_q);
  end
endmodule

// File: rtl/uart_irq_regs_chk.sv
module uart_irq_regs_chk #(
  parameter int unsigned       N      = 13,
  parameter int unsigned       ADDR_W = 8,
  parameter int unsigned       DATA_W = 32,
  parameter logic [ADDR_W-1:0] A_SET  = 8'h08,
  parameter logic [ADDR_W-1:0] A_CLR  = 8'h0C,
  parameter logic [ADDR_W-1:0] A_MASK = 8'h10,
  parameter logic [ADDR_W-1:0] A_STAT = 8'h14
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic [N-1:0]      wbits_i,
  input logic [DATA_W-1:0] rdata_i,
  input logic [N-1:0]      event_i,
  input logic              irq_i,
  input logic [N-1:0]      mask_i,
  input logic [N-1:0]      status_i
);
  logic stat_wr, mask_wr;
  assign stat_wr = wr_en_i && (addr_i == A_STAT);
  assign mask_wr = wr_en_i && ((addr_i == A_SET) || (addr_i == A_CLR));

  for (genvar k = 0; k < N; k++) begin : g_bit
    // R5: pending bit survives unless a clear targets it
    assert_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      status_i[k] && !(stat_wr && wbits_i[k]) |=> status_i[k]);
    // R7 / R8: an event always leaves its bit set
    assert_event_sets_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      event_i[k] |=> status_i[k]);
    assert_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stat_wr && wbits_i[k] && !event_i[k] |=> !status_i[k]);
  end

  assert_mask_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_wr |=> $stable(mask_i));

  assert_irq_follow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i == $past(|(status_i & mask_i)));

  assert_read_mask_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_MASK) |-> (rdata_i == DATA_W'(mask_i)));

  assert_read_stat_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_STAT) |-> (rdata_i == DATA_W'(status_i)));
endmodule

bind uart_irq_regs uart_irq_regs_chk #(
  .N(N), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .A_SET(A_SET), .A_CLR(A_CLR), .A_MASK(A_MASK), .A_STAT(A_STAT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
  .wbits_i(wdata_i[N-1:0]), .rdata_i(rdata_o), .event_i(event_i),
  .irq_i(irq_o), .mask_i(mask_q), .status_i(status_q)
);

// File: tb/uart_irq_regs_bench.sv
module uart_irq_regs_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [12:0] ev = '0;
  logic        irq;

  int    n_chk = 0;
  int    n_bad = 0;
  string cur_req = "R1";

  logic [12:0] m_mask = '0;
  logic [12:0] m_stat = '0;
  logic        m_irq  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_regs u_uart_irq_regs (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .event_i(ev), .irq_o(irq)
  );

  function automatic logic [31:0] exp_read(logic [7:0] a);
    case (a)
      8'h10:   return {19'b0, m_mask};
      8'h14:   return {19'b0, m_stat};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check32(string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  // Called just after a falling edge; returns just after the next one.
  task automatic step(logic w, logic [7:0] a, logic [31:0] d, logic [12:0] e);
    logic irq_n;
    we = w; addr = a; wdata = d; ev = e;
    #1;
    check32("rdata", rdata, exp_read(a));
    @(posedge clk);
    irq_n = |(m_stat & m_mask);
    if (w) begin
      case (a)
        8'h08: m_mask = m_mask | d[12:0];
        8'h0C: m_mask = m_mask & ~d[12:0];
        8'h14: m_stat = m_stat & ~d[12:0];
        default: ;
      endcase
    end
    m_stat = m_stat | e;
    m_irq  = irq_n;
    @(negedge clk);
    check32("irq", {31'b0, irq}, {31'b0, m_irq});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    cur_req = "R1";
    addr = 8'h10; #1; check32("mask after reset", rdata, 32'h0);
    addr = 8'h14; #1; check32("status after reset", rdata, 32'h0);
    check32("irq after reset", {31'b0, irq}, 32'h0);
    @(negedge clk);

    cur_req = "R2";
    step(1, 8'h08, 32'h0000_0005, '0);
    step(1, 8'h08, 32'h0000_0100, '0);
    step(0, 8'h10, 32'h0, '0);
    check32("mask set-only", {19'b0, m_mask}, 32'h105);

    cur_req = "R4";
    step(1, 8'h10, 32'hFFFF_FFFF, '0);
    step(1, 8'h00, 32'hFFFF_FFFF, '0);
    step(0, 8'h10, 32'h0, '0);
    step(0, 8'h14, 32'h0, '0);

    cur_req = "R3";
    step(1, 8'h0C, 32'h0000_0004, '0);
    step(0, 8'h10, 32'h0, '0);

    cur_req = "R8";
    step(0, 8'h14, 32'h0, 13'h1000);    // bit 12 transmit overflow, masked off
    step(0, 8'h14, 32'h0, '0);          // pending, irq low

    cur_req = "R11";
    step(0, 8'h14, 32'h0, 13'h0001);    // bit 0 receive threshold, masked in
    cur_req = "R9";
    step(0, 8'h14, 32'h0, '0);          // irq rises here
    cur_req = "R5";
    repeat (4) step(0, 8'h14, 32'h0, '0);

    cur_req = "R6";
    step(1, 8'h14, 32'h0000_1000, '0);
    step(1, 8'h14, 32'h0000_0000, '0);
    step(0, 8'h14, 32'h0, '0);

    cur_req = "R7";
    step(1, 8'h14, 32'h0000_0001, 13'h0001);
    step(0, 8'h14, 32'h0, '0);

    cur_req = "R9";
    step(1, 8'h14, 32'h0000_0001, '0);
    step(0, 8'h10, 32'h0, '0);          // irq falls here

    cur_req = "R12";
    step(1, 8'h08, 32'h0000_1FFF, 13'h1FFF);
    step(1, 8'h0C, 32'h0000_1FFF, '0);
    step(1, 8'h14, 32'h0000_1FFF, '0);
    step(0, 8'h10, 32'h0, '0);
    step(0, 8'h14, 32'h0, '0);

    cur_req = "R10";
    step(0, 8'h08, 32'h0, '0);
    step(0, 8'h0C, 32'h0, '0);
    step(0, 8'h3C, 32'h0, '0);

    cur_req = "R9 R10 random";
    for (int i = 0; i < 3000; i++) begin
      logic [7:0]  a;
      logic [31:0] d;
      case ($urandom_range(0, 5))
        0: a = 8'h08;
        1: a = 8'h0C;
        2: a = 8'h10;
        3: a = 8'h14;
        4: a = 8'h00;
        default: a = 8'h18;
      endcase
      d = $urandom;
      if ($urandom_range(0, 3) == 0) d = d & 32'h0000_1FFF;
      step(logic'($urandom_range(0, 1)), a, d,
           13'($urandom & $urandom & $urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule